// File: doc/BRIEF.md
# Quadrature Counter with Safe Latch

This block turns a two-phase incremental encoder signal pair into a position count. Each phase input passes through a multi-flop synchroniser. A phase discriminator then compares the new sample with the previous one. Any single-phase transition moves the count by one, so a full encoder cycle yields four counts. The order of the phases selects whether the count goes up or down. A sample in which both phases toggle together is rejected as an invalid step and flagged. The count is a modulo-2^WIDTH up/down register. Single-cycle carry and borrow pulses mark its wrap points, so a wider position can be built by cascading blocks.

A second register gives software-facing logic a stable snapshot of the count. While the active-low strobe is held low, the snapshot follows the count. While the strobe is high, the snapshot is frozen. The strobe may change at any moment relative to the encoder. A set/reset hold stage keeps the snapshot enable inactive while a count is being detected or applied, and for a fixed guard window of HOLD_CYCLES clocks after a detected edge. A strobe that lands close to an edge therefore never records the pre-edge value; the first value it records is the post-edge count.

Top module: `quad_latch_counter`

## Requirements
- R1: Every transition in which exactly one of enc_a, enc_b changes moves count_o by exactly one, so one full quadrature cycle moves it by four.
- R2: With the phase pair written {enc_a, enc_b}, the order 00 -> 10 -> 11 -> 01 -> 00 counts up and the opposite order counts down.
- R3: count_o is WIDTH bits wide and wraps modulo 2^WIDTH; 2^WIDTH forward steps return it to its starting value.
- R4: A sample in which enc_a and enc_b both change leaves count_o unchanged and raises step_err_o for exactly one clock.
- R5: carry_o is high for exactly one clock when an up count wraps from all-ones to zero, and never together with borrow_o.
- R6: borrow_o is high for exactly one clock when a down count wraps from zero to all-ones.
- R7: While strobe_n is high, latched_o keeps its value regardless of counting.
- R8: While strobe_n is low and no count is in progress, latched_o follows count_o, one clock behind it.
- R9: When strobe_n falls in the same sample as an encoder edge, or within the guard window after it, latched_o takes the post-edge count as its first new value and never shows the pre-edge count.
- R10: While rst_n is low, count_o, latched_o, carry_o, borrow_o and step_err_o are zero. Reset is applied asynchronously and released synchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| strobe_n | input | 1 | Active-low snapshot strobe, asynchronous |
| count_o | output | WIDTH | Live position count |
| latched_o | output | WIDTH | Snapshot of the count |
| carry_o | output | 1 | One-clock pulse on up wrap |
| borrow_o | output | 1 | One-clock pulse on down wrap |
| step_err_o | output | 1 | One-clock pulse on an invalid double-phase step |

## Verification
The bench builds the block with WIDTH 8, SYNC_STAGES 2 and HOLD_CYCLES 3. With an 8-bit count, a full wrap takes only 256 steps, so both wrap pulses and the return to the starting value after a full lap can be observed directly. A three-clock guard window gives room to drop the strobe both in the same sample as an edge and one clock after it. At every clock of those runs, the snapshot is checked to be either the old frozen value or the post-edge count, and never the pre-edge count.

// File: rtl/qlc_pkg.sv
package qlc_pkg;

  typedef enum logic [1:0] {
    MOVE_NONE = 2'd0,
    MOVE_UP   = 2'd1,
    MOVE_DOWN = 2'd2,
    MOVE_BAD  = 2'd3
  } move_e;

  // phase pair packed as {a, b}
  function automatic move_e classify_move(input logic [1:0] prev_ab,
                                          input logic [1:0] cur_ab);
    logic [1:0] diff;
    diff = prev_ab ^ cur_ab;
    if (diff == 2'b00) begin
      return MOVE_NONE;
    end else if (diff == 2'b11) begin
      return MOVE_BAD;
    end else if ((cur_ab[1] ^ prev_ab[0]) == 1'b1) begin
      return MOVE_UP;
    end else begin
      return MOVE_DOWN;
    end
  endfunction

endpackage

// File: rtl/qlc_sync.sv
module qlc_sync #(
  parameter int                STAGES    = 2,
  parameter int                BITS      = 1,
  parameter logic [BITS-1:0]   RESET_VAL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BITS-1:0] din,
  output logic [BITS-1:0] dout
);

  logic [BITS-1:0] chain_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [BITS-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = din;
    end else begin : g_next
      assign stage_d = chain_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q[g] <= RESET_VAL;
      end else begin
        chain_q[g] <= stage_d;
      end
    end
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/qlc_phase_disc.sv
module qlc_phase_disc #(
  parameter int SETTLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_s,
  input  logic b_s,
  output logic det_o,
  output logic step_o,
  output logic up_o,
  output logic bad_o
);
  import qlc_pkg::*;

  localparam int CW = $clog2(SETTLE + 1);

  logic [1:0]    prev_q;
  logic [CW-1:0] warm_q, warm_d;
  logic          step_q, step_d;
  logic          up_q, up_d;
  logic          bad_q, bad_d;
  logic          armed;
  move_e         move;

  always_comb begin
    move   = classify_move(prev_q, {a_s, b_s});
    armed  = (warm_q == '0);
    det_o  = armed && ((move == MOVE_UP) || (move == MOVE_DOWN));
    step_d = det_o;
    up_d   = (move == MOVE_UP);
    bad_d  = armed && (move == MOVE_BAD);
    warm_d = armed ? warm_q : warm_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 2'b00;
      warm_q <= CW'(SETTLE);
      step_q <= 1'b0;
      up_q   <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      prev_q <= {a_s, b_s};
      warm_q <= warm_d;
      step_q <= step_d;
      up_q   <= up_d;
      bad_q  <= bad_d;
    end
  end

  assign step_o = step_q;
  assign up_o   = up_q;
  assign bad_o  = bad_q;

endmodule

// File: rtl/qlc_updown.sv
module qlc_updown #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             up_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_o,
  output logic             borrow_o
);

  localparam logic [WIDTH-1:0] TOP = '1;

  logic [WIDTH-1:0] count_q, count_d;
  logic             carry_q, carry_d;
  logic             borrow_q, borrow_d;

  always_comb begin
    count_d  = up_i ? count_q + WIDTH'(1) : count_q - WIDTH'(1);
    carry_d  = step_i && up_i && (count_q == TOP);
    borrow_d = step_i && !up_i && (count_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      carry_q  <= 1'b0;
      borrow_q <= 1'b0;
    end else begin
      if (step_i) begin
        count_q <= count_d;
      end
      carry_q  <= carry_d;
      borrow_q <= borrow_d;
    end
  end

  assign count_o  = count_q;
  assign carry_o  = carry_q;
  assign borrow_o = borrow_q;

endmodule

// File: rtl/qlc_latch_hold.sv
module qlc_latch_hold #(
  parameter int WIDTH       = 8,
  parameter int HOLD_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_low_i,
  input  logic             det_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] count_i,
  output logic             latch_en_o,
  output logic [WIDTH-1:0] latched_o
);

  localparam int HW = $clog2(HOLD_CYCLES + 1);

  logic [HW-1:0]    guard_q, guard_d;
  logic             busy;
  logic             en_q, en_d;
  logic [WIDTH-1:0] latched_q;

  always_comb begin
    if (det_i) begin
      guard_d = HW'(HOLD_CYCLES);
    end else if (guard_q != '0) begin
      guard_d = guard_q - HW'(1);
    end else begin
      guard_d = guard_q;
    end
    busy = det_i || step_i || (guard_q != '0);
    // set when strobe low and idle, reset when strobe returns high
    en_d = strobe_low_i && (en_q || !busy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guard_q   <= '0;
      en_q      <= 1'b0;
      latched_q <= '0;
    end else begin
      guard_q <= guard_d;
      en_q    <= en_d;
      if (en_q) begin
        latched_q <= count_i;
      end
    end
  end

  assign latch_en_o = en_q;
  assign latched_o  = latched_q;

endmodule

// File: rtl/quad_latch_counter.sv
module quad_latch_counter #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             strobe_n,
  output logic [WIDTH-1:0] count_o,
  output logic [WIDTH-1:0] latched_o,
  output logic             carry_o,
  output logic             borrow_o,
  output logic             step_err_o
);

  localparam int SETTLE = SYNC_STAGES + 1;

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic [2:0] in_s;
  logic       det, step, up;
  logic       latch_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  qlc_sync #(
    .STAGES   (SYNC_STAGES),
    .BITS     (3),
    .RESET_VAL(3'b100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .din  ({strobe_n, enc_a, enc_b}),
    .dout (in_s)
  );

  qlc_phase_disc #(
    .SETTLE(SETTLE)
  ) u_disc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .a_s   (in_s[1]),
    .b_s   (in_s[0]),
    .det_o (det),
    .step_o(step),
    .up_o  (up),
    .bad_o (step_err_o)
  );

  qlc_updown #(
    .WIDTH(WIDTH)
  ) u_count (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .step_i  (step),
    .up_i    (up),
    .count_o (count_o),
    .carry_o (carry_o),
    .borrow_o(borrow_o)
  );

  qlc_latch_hold #(
    .WIDTH      (WIDTH),
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_hold (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .strobe_low_i(!in_s[2]),
    .det_i       (det),
    .step_i      (step),
    .count_i     (count_o),
    .latch_en_o  (latch_en),
    .latched_o   (latched_o)
  );

endmodule

// File: rtl/qlc_checker.sv
module qlc_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic [WIDTH-1:0] count_o,
  input logic [WIDTH-1:0] latched_o,
  input logic             carry_o,
  input logic             borrow_o,
  input logic             step_err_o,
  input logic             latch_en
);

  p_step_by_one_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (count_o == $past(count_o)) ||
    (count_o == $past(count_o) + WIDTH'(1)) ||
    (count_o == $past(count_o) - WIDTH'(1)));

  p_err_no_count_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step_err_o |=> $stable(count_o));

  p_carry_wrap_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    carry_o |-> ((count_o == '0) && ($past(count_o) == '1)));

  p_flags_apart_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(carry_o && borrow_o));

  p_borrow_wrap_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    borrow_o |-> ((count_o == '1) && ($past(count_o) == '0)));

  p_latch_frozen_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !latch_en |=> $stable(latched_o));

  p_latch_follow_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    latch_en |=> (latched_o == $past(count_o)));

endmodule

bind quad_latch_counter qlc_checker #(.WIDTH(WIDTH)) u_qlc_checker (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .count_o   (count_o),
  .latched_o (latched_o),
  .carry_o   (carry_o),
  .borrow_o  (borrow_o),
  .step_err_o(step_err_o),
  .latch_en  (latch_en)
);

// File: tb/tb_quad_latch_counter.sv
module tb_quad_latch_counter;

  localparam int WIDTH = 8;
  localparam int HOLD  = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             enc_a, enc_b, strobe_n;
  logic [WIDTH-1:0] count_o, latched_o;
  logic             carry_o, borrow_o, step_err_o;

  int tests = 0;
  int fails = 0;
  int carry_seen = 0, borrow_seen = 0, err_seen = 0;
  int pos = 0;
  logic [WIDTH-1:0] exp_cnt = '0;
  bit done = 0;

  always #10 clk = ~clk;

  quad_latch_counter #(.WIDTH(WIDTH), .SYNC_STAGES(2), .HOLD_CYCLES(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .strobe_n(strobe_n),
    .count_o(count_o), .latched_o(latched_o), .carry_o(carry_o),
    .borrow_o(borrow_o), .step_err_o(step_err_o)
  );

  always @(negedge clk) begin
    if (carry_o)    carry_seen++;
    if (borrow_o)   borrow_seen++;
    if (step_err_o) err_seen++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  function automatic logic [1:0] ab_of(input int p);
    case (p & 3)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  // drive the encoder by delta positions in the forward order, at a negedge
  task automatic drive(input int delta);
    logic [1:0] ab;
    pos = (pos + delta) & 3;
    ab = ab_of(pos);
    enc_a = ab[1];
    enc_b = ab[0];
  endtask

  task automatic step(input bit fwd);
    @(negedge clk);
    drive(fwd ? 1 : 3);
    exp_cnt = fwd ? exp_cnt + 1'b1 : exp_cnt - 1'b1;
    settle();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; enc_a = 1'b0; enc_b = 1'b0; strobe_n = 1'b1; pos = 0; exp_cnt = '0;
    repeat (3) @(negedge clk);
    check(count_o == 0, "R10 count in reset", count_o, 0);
    check(latched_o == 0, "R10 latched in reset", latched_o, 0);
    check({carry_o, borrow_o, step_err_o} == 0, "R10 flags in reset",
          {carry_o, borrow_o, step_err_o}, 0);
    rst_n = 1'b1;
    settle();
    check(count_o == 0, "R10 count after release", count_o, 0);
  endtask

  task automatic t_forward();
    for (int i = 0; i < 4; i++) begin
      step(1'b1);
      check(count_o == exp_cnt, "R1 R2 forward step", count_o, exp_cnt);
    end
    check(count_o == 4, "R1 four counts per cycle", count_o, 4);
  endtask

  task automatic t_reverse();
    for (int i = 0; i < 4; i++) begin
      step(1'b0);
      check(count_o == exp_cnt, "R2 reverse step", count_o, exp_cnt);
    end
  endtask

  task automatic t_invalid();
    err_seen = 0;
    @(negedge clk);
    drive(2);
    settle();
    check(count_o == exp_cnt, "R4 invalid step no count", count_o, exp_cnt);
    check(err_seen == 1, "R4 error pulse count", err_seen, 1);
  endtask

  task automatic t_wraps();
    borrow_seen = 0; carry_seen = 0;
    step(1'b0);
    check(count_o == 255, "R6 down wrap value", count_o, 255);
    check(borrow_seen == 1, "R6 borrow pulses", borrow_seen, 1);
    step(1'b1);
    check(count_o == 0, "R5 up wrap value", count_o, 0);
    check(carry_seen == 1, "R5 carry pulses", carry_seen, 1);
    check(borrow_seen == 1, "R5 no borrow on up", borrow_seen, 1);
  endtask

  task automatic t_full_lap();
    logic [WIDTH-1:0] start;
    start = count_o;
    carry_seen = 0;
    for (int i = 0; i < 256; i++) step(1'b1);
    check(count_o == start, "R3 lap returns to start", count_o, start);
    check(carry_seen == 1, "R3 one carry per lap", carry_seen, 1);
  endtask

  task automatic t_follow();
    for (int i = 0; i < 5; i++) step(1'b1);
    @(negedge clk); strobe_n = 1'b0;
    settle();
    check(latched_o == 5, "R8 snapshot follows", latched_o, 5);
    step(1'b1);
    check(latched_o == 6, "R8 snapshot tracks while low", latched_o, 6);
    @(negedge clk); strobe_n = 1'b1;
    settle();
  endtask

  task automatic t_frozen();
    for (int i = 0; i < 3; i++) step(1'b1);
    check(count_o == 9, "R7 count moved", count_o, 9);
    check(latched_o == 6, "R7 snapshot frozen", latched_o, 6);
  endtask

  // strobe drops lag clocks after an edge; snapshot may only be old or post
  task automatic t_deferred(input int lag, input logic [WIDTH-1:0] old_v);
    logic [WIDTH-1:0] post;
    bit bad = 0;
    logic [WIDTH-1:0] seen = '0;
    @(negedge clk);
    drive(1);
    exp_cnt = exp_cnt + 1'b1;
    post = exp_cnt;
    for (int i = 0; i < lag; i++) @(negedge clk);
    strobe_n = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (latched_o != old_v && latched_o != post && !bad) begin
        bad = 1; seen = latched_o;
      end
    end
    check(!bad, "R9 no pre-edge snapshot", seen, post);
    check(latched_o == post, "R9 post-edge snapshot", latched_o, post);
    @(negedge clk); strobe_n = 1'b1;
    settle();
  endtask

  task automatic t_reset_again();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(count_o == 0 && latched_o == 0, "R10 mid-run reset", count_o, 0);
    rst_n = 1'b1;
    settle();
  endtask

  initial begin
    t_reset();
    t_forward();
    t_reverse();
    t_invalid();
    t_wraps();
    t_full_lap();
    t_follow();
    t_frozen();
    t_deferred(0, 8'd6);
    step(1'b1);
    t_deferred(1, 8'd10);
    t_reset_again();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule